// File: doc/BRIEF.md
# Dual-Channel DMA Local Bus Arbiter

This block decides which of two DMA channels owns a shared local bus. Each channel raises a request line and the arbiter answers with a registered one-hot grant. Ownership is bounded by an optional hold limit. The limit counts clock cycles from the moment a grant is given. Once a grant ends, an optional cool-down keeps that channel off the bus for a programmable number of cycles.

When both channels are eligible at once, a two-bit field picks the winner. Either one channel always wins, or the winner alternates so that the channel granted last loses. A gating option makes the hold counter advance only while some other bus master is asking for the bus. An enable bit lets the arbiter show an outgoing bus-request signal while it holds a grant.

All settings come from one 32-bit configuration word, sampled every cycle. The request/grant pair is a plain level handshake, not a data stream, so there is no valid/ready back-pressure. A channel keeps its request high for as long as it wants the bus. The arbiter takes the grant away when the request falls, when the hold limit is reached, or at reset.

Top module: `dma_bus_arb`

## Requirements
- R1: After reset no grant is given and `bus_req_o` is low. The first two-way tie in alternating mode goes to channel 0.
- R2: The grant is one-hot or zero. When no grant is active and some channel is eligible (request high, no cool-down running), a grant is issued at the next clock edge. A grant never passes directly from one channel to the other: at least one cycle with no grant lies between any two grants.
- R3: With `cfg_i[16]` set, a grant lasts at most L+1 counting cycles, where L is `cfg_i[7:0]`. A channel holding its request with the gate off therefore sees exactly L+1 cycles of grant. With `cfg_i[16]` clear, the grant holds as long as the request does.
- R4: With `cfg_i[17]` set, a channel whose grant ends stays ungranted for at least P+1 cycles, where P is `cfg_i[15:8]`. With `cfg_i[17]` clear, the gap is one cycle.
- R5: `cfg_i[20:19]` = 1 makes channel 0 win every tie. A value of 2 makes channel 1 win every tie.
- R6: `cfg_i[20:19]` = 0 or 3 selects alternating priority: a tie goes to the channel that was not granted most recently.
- R7: With `cfg_i[27]` set, the hold counter advances only in cycles where `ext_req_i` is high. While `ext_req_i` is low, the grant is never cut short by the hold limit.
- R8: A grant falls at the first clock edge at which its channel's request is seen low.
- R9: `bus_req_o` is high exactly while a grant is active and `cfg_i[18]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_i | input | 32 | Configuration word (field positions as in the requirements) |
| req_i | input | 2 | Per-channel bus request, bit n for channel n |
| ext_req_i | input | 1 | Another master is asking for the bus |
| gnt_o | output | 2 | One-hot grant, bit n for channel n |
| bus_req_o | output | 1 | Outgoing bus request while a grant is held |

## Verification
The interesting collision is a hold-limit expiry that lands on the same edge where the owner drops its request. A second one is a cool-down that ends in the same cycle as a tie between both channels. Both can only release the grant once and load the cool-down once. The second case must also apply the selected priority to a channel that has just become eligible. These cases are provoked by sweeping small hold and cool-down values against pseudo-random request and external-request patterns in every priority mode. A cycle model built from the requirements judges every grant and bus-request value, and directed sequences pin down the exact cycle counts.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NCH   = 2;
  localparam int TMR_W = 8;

  typedef enum logic [1:0] {
    PRI_ALT  = 2'd0,
    PRI_CH0  = 2'd1,
    PRI_CH1  = 2'd2,
    PRI_ALT3 = 2'd3
  } pri_mode_e;

  typedef struct packed {
    logic [TMR_W-1:0] hold_lim;
    logic [TMR_W-1:0] cool_len;
    logic             hold_en;
    logic             cool_en;
    logic             breq_en;
    pri_mode_e        pri;
    logic             gate_ext;
  } arb_cfg_t;

  function automatic arb_cfg_t unpack_cfg(input logic [31:0] w);
    arb_cfg_t c;
    c.hold_lim = w[7:0];
    c.cool_len = w[15:8];
    c.hold_en  = w[16];
    c.cool_en  = w[17];
    c.breq_en  = w[18];
    c.pri      = pri_mode_e'(w[20:19]);
    c.gate_ext = w[27];
    return c;
  endfunction
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
(
  input  logic [NCH-1:0] elig_i,
  input  pri_mode_e      pri_i,
  input  logic           last_i,
  output logic           vld_o,
  output logic           idx_o
);
  always_comb begin
    vld_o = |elig_i;
    unique case (elig_i)
      2'b01:   idx_o = 1'b0;
      2'b10:   idx_o = 1'b1;
      2'b11: begin
        unique case (pri_i)
          PRI_CH0: idx_o = 1'b0;
          PRI_CH1: idx_o = 1'b1;
          default: idx_o = ~last_i;
        endcase
      end
      default: idx_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dma_arb_cool.sv
module dma_arb_cool #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         busy_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/dma_arb_hold.sv
module dma_arb_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         adv_i,
  input  logic [W-1:0] lim_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (start_i) cnt_q <= '0;
    else if (adv_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = adv_i && (cnt_q == lim_i);
endmodule

// File: rtl/dma_bus_arb.sv
module dma_bus_arb
  import dma_arb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [31:0]    cfg_i,
  input  logic [NCH-1:0] req_i,
  input  logic           ext_req_i,
  output logic [NCH-1:0] gnt_o,
  output logic           bus_req_o
);
  arb_cfg_t       cfg;
  logic [NCH-1:0] gnt_q;
  logic           last_q;
  logic           owned, own_idx, adv, expire, release_now, take;
  logic           pick_vld, pick_idx;
  logic [NCH-1:0] busy, elig;
  logic           unused_cfg;

  assign cfg        = unpack_cfg(cfg_i);
  assign unused_cfg = ^{cfg_i[31:28], cfg_i[26:21]};

  assign owned       = |gnt_q;
  assign own_idx     = gnt_q[1];
  assign adv         = owned && cfg.hold_en && (!cfg.gate_ext || ext_req_i);
  assign release_now = owned && (!req_i[own_idx] || expire);
  assign take        = !owned && pick_vld;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      dma_arb_cool #(.W(TMR_W)) u_cool (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (release_now && (own_idx == gi[0])),
        .len_i  (cfg.cool_en ? cfg.cool_len : '0),
        .busy_o (busy[gi])
      );
      assign elig[gi] = req_i[gi] && !busy[gi];

      // R4
      cool_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy[gi] |-> !gnt_q[gi]);

      // R8
      drop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q[gi] && !req_i[gi]) |=> !gnt_q[gi]);
    end
  endgenerate

  dma_arb_hold #(.W(TMR_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (take),
    .adv_i    (adv),
    .lim_i    (cfg.hold_lim),
    .expire_o (expire)
  );

  dma_arb_pick u_pick (
    .elig_i (elig),
    .pri_i  (cfg.pri),
    .last_i (last_q),
    .vld_o  (pick_vld),
    .idx_o  (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      last_q <= 1'b1;
    end else if (release_now) begin
      gnt_q  <= '0;
    end else if (take) begin
      gnt_q  <= pick_idx ? 2'b10 : 2'b01;
      last_q <= pick_idx;
    end
  end

  assign gnt_o     = gnt_q;
  assign bus_req_o = cfg.breq_en && owned;

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  // R2
  no_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owned |=> (gnt_q == $past(gnt_q) || gnt_q == '0));

  // R5
  fixed_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!owned && elig == 2'b11 && cfg.pri == PRI_CH0) |=> gnt_q == 2'b01);

  // R5
  fixed_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!owned && elig == 2'b11 && cfg.pri == PRI_CH1) |=> gnt_q == 2'b10);
endmodule

// File: tb/tb_dma_bus_arb.sv
`timescale 1ns/1ps
module tb_dma_bus_arb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic [1:0]  req = '0;
  logic        ext = 1'b0;
  logic [1:0]  gnt;
  logic        breq;

  int checks = 0;
  int fails  = 0;
  bit sweep_on = 1'b0;

  always #2 clk = ~clk;

  dma_bus_arb dut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .req_i(req),
    .ext_req_i(ext), .gnt_o(gnt), .bus_req_o(breq)
  );

  function automatic logic [31:0] mk_cfg(int lim, int cool, bit hen, bit cen,
                                         bit ben, int pri, bit gate);
    logic [31:0] w = '0;
    w[7:0] = lim[7:0]; w[15:8] = cool[7:0];
    w[16] = hen; w[17] = cen; w[18] = ben; w[20:19] = pri[1:0]; w[27] = gate;
    return w;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; ext = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
  endtask

  // Requirement-level cycle model
  logic [1:0] m_gnt;
  int         m_cnt, m_p0, m_p1;
  bit         m_last;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gnt = 0; m_cnt = 0; m_p0 = 0; m_p1 = 0; m_last = 1'b1;
    end else begin
      int lim, cl, np0, np1, o;
      bit hen, adv, rel, e0, e1, pk;
      lim = cfg[7:0]; cl = cfg[17] ? int'(cfg[15:8]) : 0; hen = cfg[16];
      np0 = (m_p0 > 0) ? m_p0 - 1 : 0;
      np1 = (m_p1 > 0) ? m_p1 - 1 : 0;
      if (m_gnt != 0) begin
        o = m_gnt[1] ? 1 : 0;
        adv = hen && (!cfg[27] || ext);
        rel = !req[o] || (adv && m_cnt == lim);
        if (rel) begin
          m_gnt = 0;
          if (o == 0) np0 = cl; else np1 = cl;
        end else if (adv) m_cnt = m_cnt + 1;
      end else begin
        e0 = req[0] && m_p0 == 0; e1 = req[1] && m_p1 == 0;
        if (e0 || e1) begin
          if (e0 && e1) pk = (cfg[20:19] == 2'd1) ? 1'b0 :
                             (cfg[20:19] == 2'd2) ? 1'b1 : !m_last;
          else pk = e1;
          m_gnt = pk ? 2'b10 : 2'b01; m_last = pk; m_cnt = 0;
        end
      end
      m_p0 = np0; m_p1 = np1;
    end
  end

  always @(negedge clk) begin
    if (sweep_on && rst_n) begin
      chk(gnt == m_gnt, "R3/R4/R5/R6/R7 sweep gnt", gnt, m_gnt);
      chk(breq == (cfg[18] && m_gnt != 0), "R9 sweep bus_req", breq,
          int'(cfg[18] && m_gnt != 0));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] lf;
    // R1: reset state
    do_reset();
    chk(gnt == 0, "R1 gnt after reset", gnt, 0);
    chk(breq == 0, "R1 bus_req after reset", breq, 0);

    // R2 / R8 / R9: single channel, no hold limit
    cfg = mk_cfg(0, 0, 0, 0, 0, 0, 0);
    req = 2'b10; step();
    chk(gnt == 2'b10, "R2 grant one edge after request", gnt, 2);
    chk(breq == 0, "R9 bus_req disabled", breq, 0);
    cfg[18] = 1'b1; step();
    chk(breq == 1, "R9 bus_req enabled while granted", breq, 1);
    req = 2'b00; step();
    chk(gnt == 0, "R8 grant drops after request drop", gnt, 0);
    chk(breq == 0, "R9 bus_req low with no grant", breq, 0);

    // R3 hold limit 3, R4 cool-down off then on
    do_reset();
    cfg = mk_cfg(3, 2, 1, 0, 0, 0, 0);
    req = 2'b01; step();
    n = 0; while (gnt == 2'b01 && n < 50) begin n++; step(); end
    chk(n == 4, "R3 grant length L+1", n, 4);
    n = 0; while (gnt == 0 && n < 50) begin n++; step(); end
    chk(n == 1, "R4 gap with cool-down off", n, 1);
    do_reset();
    cfg = mk_cfg(3, 2, 1, 1, 0, 0, 0);
    req = 2'b01; step();
    n = 0; while (gnt == 2'b01 && n < 50) begin n++; step(); end
    chk(n == 4, "R3 grant length with cool-down", n, 4);
    n = 0; while (gnt == 0 && n < 50) begin n++; step(); end
    chk(n == 3, "R4 gap P+1", n, 3);

    // R6 alternating, modes 0 and 3
    for (int m = 0; m < 4; m += 3) begin
      do_reset();
      cfg = mk_cfg(0, 0, 1, 0, 0, m, 0);
      req = 2'b11; step();
      chk(gnt == 2'b01, "R6 first tie to ch0", gnt, 1); step();
      chk(gnt == 2'b00, "R6 idle between grants", gnt, 0); step();
      chk(gnt == 2'b10, "R6 second tie to ch1", gnt, 2); step();
      chk(gnt == 2'b00, "R6 idle between grants", gnt, 0); step();
      chk(gnt == 2'b01, "R6 third tie to ch0", gnt, 1);
    end

    // R5 fixed priority
    do_reset();
    cfg = mk_cfg(0, 0, 1, 0, 0, 2, 0);
    req = 2'b11; step();
    chk(gnt == 2'b10, "R5 ch1 fixed first", gnt, 2); step(); step();
    chk(gnt == 2'b10, "R5 ch1 fixed again", gnt, 2);
    do_reset();
    cfg = mk_cfg(0, 0, 1, 0, 0, 1, 0);
    req = 2'b11; step(); step(); step();
    chk(gnt == 2'b01, "R5 ch0 fixed again", gnt, 1);

    // R7 gated hold counter
    do_reset();
    cfg = mk_cfg(0, 0, 1, 0, 0, 0, 1);
    req = 2'b01; ext = 1'b0;
    repeat (10) step();
    chk(gnt == 2'b01, "R7 held while ext idle", gnt, 1);
    ext = 1'b1; step();
    chk(gnt == 2'b00, "R7 expiry once ext requests", gnt, 0);

    // Sweep over small configurations against the model
    lf = 16'hACE1;
    for (int c = 0; c < 512; c++) begin
      do_reset();
      cfg = mk_cfg(c % 4, (c / 4) % 4, c[4], c[5], 1'b1, (c / 64) % 4, c[6]);
      sweep_on = 1'b1;
      for (int k = 0; k < 40; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[0] && lf[1]) req[0] = ~req[0];
        if (lf[2] && lf[3]) req[1] = ~req[1];
        ext = lf[5];
        step();
      end
      sweep_on = 1'b0;
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule